// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised storage register, eight bits by default, with four operations picked by a two-bit mode select: keep the current value, shift toward the high end, shift toward the low end, or capture a whole word. All changes to the register take effect on the rising clock edge. The only exception is an asynchronous active-low reset, which clears the register at once.

The register's parallel output and its parallel load input share one port. In this form that port is split into three signals: an inbound word, an outbound word and a drive-enable. Whatever sits outside the block turns these into a real bus. The block drives the port only when both active-low output enables are asserted and the mode is not capture. In capture mode the port is always released, so the incoming word can be sampled without contention.

Each shift direction has its own serial input. The two end bits have dedicated outputs that ignore the enables and the mode, so several blocks can be chained into a longer register.

Top module: `usr_shift_bus`

## Requirements
- R1: Driving rst_ni low clears every register bit immediately, without waiting for a clock edge, and lsb_o, msb_o and the register word are zero while it stays low.
- R2: While rst_ni is low, rising clock edges do not change the register, whatever the mode. The first rising edge after rst_ni returns high performs the selected operation normally.
- R3: Mode 2'b00 (mode_i[1], mode_i[0]) holds the register unchanged across a clock edge.
- R4: Mode 2'b01 shifts toward the high end on a rising edge: bit 0 takes ser_r_i, bit i+1 takes the old bit i, and the old top bit is lost.
- R5: Mode 2'b10 shifts toward the low end on a rising edge: the top bit takes ser_l_i, bit i takes the old bit i+1, and the old bit 0 is lost.
- R6: Mode 2'b11 captures bus_i into the register on a rising edge.
- R7: bus_oe_o is 1 exactly when oe_n_i is 2'b00 and mode_i is not 2'b11. Any enable bit that is high, or capture mode, releases the port.
- R8: bus_o equals the register word while bus_oe_o is 1, and is all zeros while bus_oe_o is 0.
- R9: lsb_o and msb_o always show register bit 0 and the top register bit, whatever oe_n_i and mode_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 capture |
| ser_r_i | input | 1 | Serial bit that enters bit 0 on a shift up |
| ser_l_i | input | 1 | Serial bit that enters the top bit on a shift down |
| oe_n_i | input | 2 | Output enables, active low; both must be low to drive |
| bus_i | input | WIDTH | Inbound half of the shared port |
| bus_o | output | WIDTH | Outbound half of the shared port |
| bus_oe_o | output | 1 | High when the block drives the shared port |
| lsb_o | output | 1 | Register bit 0, always driven |
| msb_o | output | 1 | Top register bit, always driven |

## Verification
Two things can happen in the same cycle: the asynchronous reset and a clocked capture or shift. The bench loads a nonzero word and drops reset in the middle of a clock phase, then checks the cleared outputs before the next edge arrives. It keeps reset low across several edges with capture mode and an all-ones inbound word on the port. It then releases reset between edges and checks that the very next edge performs the capture. Port ownership and the capture mode also meet in a single cycle. A long pseudo-random sweep covers every mode and enable pattern and checks the drive-enable against the rule in R7.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  usr_mode_e        mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] d_o
);
  localparam int TOP = WIDTH - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic from_lo, from_hi;
    if (b == 0) begin : g_lo_edge
      assign from_lo = ser_r_i;
    end else begin : g_lo_mid
      assign from_lo = q_i[b-1];
    end
    if (b == TOP) begin : g_hi_edge
      assign from_hi = ser_l_i;
    end else begin : g_hi_mid
      assign from_hi = q_i[b+1];
    end
    assign d_o[b] = (mode_i == MODE_HOLD) ? q_i[b]  :
                    (mode_i == MODE_SHUP) ? from_lo :
                    (mode_i == MODE_SHDN) ? from_hi : bus_i[b];
  end
endmodule

// File: rtl/usr_store.sv
module usr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0)
    else $error("R1: register not clear under reset");
endmodule

// File: rtl/usr_port.sv
module usr_port
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  usr_mode_e        mode_i,
  input  logic [1:0]       oe_n_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o
);
  assign bus_oe_o = (oe_n_i == 2'b00) && (mode_i != MODE_LOAD);
  assign bus_o    = bus_oe_o ? q_i : '0;

  // port must be released whenever capture is selected
  assert_release_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |-> !bus_oe_o)
    else $error("R7: port driven in capture mode");

  assert_quiet_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0)
    else $error("R8: port data nonzero while released");
endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [1:0]       oe_n_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             lsb_o,
  output logic             msb_o
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode;
  logic [WIDTH-1:0] q, d;

  assign mode = usr_mode_e'(mode_i);

  usr_next #(.WIDTH(WIDTH)) u_next (
    .mode_i(mode), .ser_r_i(ser_r_i), .ser_l_i(ser_l_i),
    .q_i(q), .bus_i(bus_i), .d_o(d)
  );

  usr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d), .q_o(q)
  );

  usr_port #(.WIDTH(WIDTH)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .oe_n_i(oe_n_i),
    .q_i(q), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  assign lsb_o = q[0];
  assign msb_o = q[TOP];

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HOLD) |=> $stable(q))
    else $error("R3: hold changed register");

  assert_shup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SHUP) |=> (q == {$past(q[TOP-1:0]), $past(ser_r_i)}))
    else $error("R4: shift up wrong");

  assert_shdn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SHDN) |=> (q == {$past(ser_l_i), $past(q[TOP:1])}))
    else $error("R5: shift down wrong");

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LOAD) |=> (q == $past(bus_i)))
    else $error("R6: capture wrong");
endmodule

// File: tb/sim_usr_shift_bus.sv
module sim_usr_shift_bus;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ser_r = 1'b0, ser_l = 1'b0;
  logic [1:0]   oe_n = 2'b11;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic         bus_oe, lsb, msb;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] model = '0;
  logic [15:0]  lfsr = 16'hACE1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usr_shift_bus #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_r_i(ser_r), .ser_l_i(ser_l),
    .oe_n_i(oe_n), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(bus_oe),
    .lsb_o(lsb), .msb_o(msb)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] step_model(input logic [1:0] m, input logic [W-1:0] q,
                                               input logic sr, input logic sl,
                                               input logic [W-1:0] bi);
    case (m)
      2'b00:   return q;
      2'b01:   return (q << 1) | W'(sr);
      2'b10:   return (q >> 1) | (W'(sl) << (W-1));
      default: return bi;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // check every port against the model under the current inputs
  task automatic check_ports(input string req);
    logic oe_exp;
    oe_exp = (oe_n == 2'b00) && (mode != 2'b11);
    check("R7", W'(bus_oe), W'(oe_exp));
    check({req, "/R8"}, bus_out, oe_exp ? model : '0);
    check({req, "/R9"}, {6'b0, msb, lsb}, {6'b0, model[W-1], model[0]});
  endtask

  // drive at negedge, clock, compare 1 time unit after the edge
  task automatic cycle(input logic [1:0] m, input logic [1:0] oe, input logic sr,
                       input logic sl, input logic [W-1:0] bi);
    @(negedge clk);
    mode = m; oe_n = oe; ser_r = sr; ser_l = sl;
    bus_in = (m == 2'b11) ? bi : '0;
    @(posedge clk);
    model = step_model(m, model, sr, sl, bus_in);
    #1;
    check_ports(tag_of(m));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {6'b0, msb, lsb}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed shifts
    cycle(2'b11, 2'b00, 0, 0, 8'hA5);   // R6 capture A5
    cycle(2'b00, 2'b00, 0, 0, '0);      // R3
    check("R6", bus_out, 8'hA5);
    cycle(2'b01, 2'b00, 1, 0, '0);      // R4
    check("R4", bus_out, 8'h4B);
    cycle(2'b10, 2'b00, 0, 0, '0);      // R5
    check("R5", bus_out, 8'h25);
    cycle(2'b10, 2'b01, 0, 1, '0);      // R5 with ser_l, port released
    check("R7", W'(bus_oe), '0);
    check("R9", {6'b0, msb, lsb}, 8'h02);

    // R1: async clear mid-phase
    cycle(2'b11, 2'b00, 0, 0, 8'hFF);
    #2;
    mode = 2'b00; oe_n = 2'b00;
    rst_n = 1'b0;
    #1;
    model = '0;
    check("R1", bus_out, '0);
    check("R1", {6'b0, msb, lsb}, '0);

    // R2: edges during reset with capture of all ones
    @(negedge clk);
    mode = 2'b11; bus_in = 8'hFF;
    repeat (3) begin
      @(posedge clk); #1;
      check("R2", {6'b0, msb, lsb}, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    model = 8'hFF;
    #1;
    check("R2", {6'b0, msb, lsb}, 8'h03);
    cycle(2'b00, 2'b00, 0, 0, '0);
    check("R2", bus_out, 8'hFF);

    // sweep
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[1:0], lfsr[3:2] & {lfsr[4], lfsr[4]}, lfsr[5], lfsr[6], lfsr[14:7]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule